// File: doc/BRIEF.md
# Legacy Serial Port Window Decoder

This block sits on a host I/O bus and recognises accesses aimed at one of four standard legacy serial-port windows, each eight bytes wide. A single 8-bit control register picks the window, turns the decoder on, chooses how the peripheral interrupt reaches the host, and decides whether the match is exported as an active-low chip-select on a pin that otherwise serves as a status input. When host address bits 9 to 3 fall in the selected window outside a DMA cycle, the block raises a qualified select and passes the low three address bits on as an index into an eight-entry register file that lives elsewhere.

The interrupt request from the peripheral is routed to one of two host interrupt lines, each with its own output enable so that the unused line floats. In single-line mode line 1 always carries the request. In dual mode the window choice decides the line. Two host-side status pins are synchronised and shown as read-only bits of the control register.

Top module: `serwin_decode`

## Requirements
- R1: After reset the control register reads 0x01 (bit 0 set, bits 7..3 clear), given both status pins low; `access_sel` is 0, `int1_oe` is 1, `int2_oe` is 0 and `cs_oe` is 0.
- R2: Control bits [4:3] pick the window: 0 selects 0x3F8–0x3FF, 1 selects 0x2F8–0x2FF, 2 selects 0x3E8–0x3EF, 3 selects 0x2E8–0x2EF; addresses one below and one above a window do not match.
- R3: `access_sel` is 1 only when `host_addr[9:3]` equals bits 9..3 of the selected window base and `dma_cycle` is 0; a high `dma_cycle` never produces an access.
- R4: `reg_idx` equals `host_addr[2:0]` while `access_sel` is 1 and is 0 otherwise.
- R5: With control bit 5 (decoder enable) clear, `access_sel` stays 0 for any address.
- R6: With control bit 6 (dual interrupt) set, windows 1 and 3 (odd codes) drive line 2 (`int2_oe`=1, `int1_oe`=0) and windows 0 and 2 drive line 1; exactly one line is enabled at a time; the enabled line follows `irq_req` (active high) and a disabled line outputs 0.
- R7: With control bit 6 clear, `int1_oe` is 1, `int2_oe` is 0 and `int1_out` follows `irq_req` for every window.
- R8: Control bits 1 and 2 are read-only: bit 1 shows `stat_a_in` and bit 2 shows `stat_b_in` after two clock cycles of synchronisation; written values for these bits are discarded.
- R9: When control bits 0, 5 and 7 are all set, `cs_oe` is 1 and `cs_n_out` is the inverse of `access_sel` (so it stays high in DMA cycles); otherwise `cs_oe` is 0 and `cs_n_out` is 1.
- R10: A write with `wr_en` high loads bits 7..3 and bit 0 from `wr_data` at the next rising edge; they read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write byte |
| rd_data | output | 8 | Control register read byte |
| host_addr | input | ADDR_W | Host I/O address |
| dma_cycle | input | 1 | High during a host DMA cycle; blocks decode |
| stat_a_in | input | 1 | Status pin A (shares the chip-select pin) |
| stat_b_in | input | 1 | Status pin B |
| irq_req | input | 1 | Peripheral interrupt request |
| access_sel | output | 1 | Qualified access to the register file |
| reg_idx | output | 3 | Register index inside the window |
| int1_out | output | 1 | Host interrupt line 1 level |
| int1_oe | output | 1 | Host interrupt line 1 enable |
| int2_out | output | 1 | Host interrupt line 2 level |
| int2_oe | output | 1 | Host interrupt line 2 enable |
| cs_n_out | output | 1 | Active-low chip-select level |
| cs_oe | output | 1 | Chip-select pin output enable |

## Verification
The bench builds the block with its defaults: a 10-bit address, a two-stage status synchroniser, a reset value of 0x01 and active-high interrupt lines. This puts every window edge in reach through the full 1024-entry address space, so random addresses land both inside windows and on neighbouring lines. The fixed two-cycle synchroniser depth sets when the read-only status bits are sampled. The active-high polarity lets the interrupt levels be compared directly with `irq_req`.

// File: rtl/serwin_pkg.sv
package serwin_pkg;

   typedef enum logic [1:0] {
      WIN_P1 = 2'd0,
      WIN_P2 = 2'd1,
      WIN_P3 = 2'd2,
      WIN_P4 = 2'd3
   } win_t;

   // Field layout is fixed by software: positions are part of behaviour.
   typedef struct packed {
      logic       cs_export;   // 7
      logic       dual_irq;    // 6
      logic       dec_en;      // 5
      win_t       win;         // 4:3
      logic [1:0] pin_lvl;     // 2:1 read-only
      logic       pin_mux;     // 0
   } ctrl_t;

   localparam int          CTRL_W  = 8;
   localparam logic [7:0]  RO_MASK = 8'b0000_0110;
   localparam int          DEC_LO  = 3;
   localparam int          DEC_HI  = 9;
   localparam int          IDX_W   = DEC_LO;

   // Base of each window: odd codes drop 0x100, codes 2/3 drop 0x010.
   function automatic logic [9:0] win_base(input win_t w);
      logic [9:0] b;
      b = 10'h3F8;
      if (w[0]) b = b - 10'h100;
      if (w[1]) b = b - 10'h010;
      return b;
   endfunction

endpackage

// File: rtl/serwin_ctrl_reg.sv
module serwin_ctrl_reg
   import serwin_pkg::*;
#(
   parameter logic [7:0] RST_VAL     = 8'h01,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic [1:0]        stat_in,
   output logic [CTRL_W-1:0] rd_data,
   output ctrl_t             ctrl
);

   localparam logic [CTRL_W-1:0] RW_MASK = ~RO_MASK;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("serwin_ctrl_reg: SYNC_STAGES must be at least 2");
   end

   logic [CTRL_W-1:0] stored_q;
   logic [1:0]        sync_q [SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stored_q <= RST_VAL & RW_MASK;
      end else if (wr_en) begin
         stored_q <= wr_data & RW_MASK;
      end
   end

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= '0;
            else        sync_q[s] <= stat_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= '0;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   end

   always_comb begin
      rd_data      = stored_q;
      rd_data[2:1] = sync_q[SYNC_STAGES-1];
      ctrl         = ctrl_t'(rd_data);
   end

endmodule

// File: rtl/serwin_addr_match.sv
module serwin_addr_match
   import serwin_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              dma_cycle,
   input  logic              dec_en,
   input  win_t              win,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);

   localparam int CMP_W = DEC_HI - DEC_LO + 1;

   if (ADDR_W < DEC_HI + 1) begin : g_bad_addr
      $error("serwin_addr_match: ADDR_W must cover bit 9");
   end

   logic [9:0]       base;
   logic [CMP_W-1:0] base_line;
   logic [CMP_W-1:0] addr_line;
   logic             in_win;

   always_comb begin
      base      = win_base(win);
      base_line = base[DEC_HI:DEC_LO];
      addr_line = host_addr[DEC_HI:DEC_LO];
      in_win    = (addr_line == base_line);
      hit       = dec_en && !dma_cycle && in_win;
      idx       = hit ? host_addr[IDX_W-1:0] : '0;
   end

endmodule

// File: rtl/serwin_irq_steer.sv
module serwin_irq_steer
   import serwin_pkg::*;
#(
   parameter bit IRQ_ACT_LOW = 1'b0
) (
   input  logic irq_req,
   input  logic dual_irq,
   input  win_t win,
   output logic int1_out,
   output logic int1_oe,
   output logic int2_out,
   output logic int2_oe
);

   logic to_line2;
   logic act_lvl;
   logic idle_lvl;

   if (IRQ_ACT_LOW) begin : g_low
      assign act_lvl  = ~irq_req;
      assign idle_lvl = 1'b1;
   end else begin : g_high
      assign act_lvl  = irq_req;
      assign idle_lvl = 1'b0;
   end

   always_comb begin
      to_line2 = dual_irq && win[0];
      int2_oe  = to_line2;
      int1_oe  = !to_line2;
      int1_out = int1_oe ? act_lvl : idle_lvl;
      int2_out = int2_oe ? act_lvl : idle_lvl;
   end

endmodule

// File: rtl/serwin_pin_ctl.sv
module serwin_pin_ctl (
   input  logic pin_mux,
   input  logic dec_en,
   input  logic cs_export,
   input  logic hit,
   output logic cs_n_out,
   output logic cs_oe
);

   always_comb begin
      cs_oe    = pin_mux && dec_en && cs_export;
      cs_n_out = !(cs_oe && hit);
   end

endmodule

// File: rtl/serwin_decode.sv
module serwin_decode
   import serwin_pkg::*;
#(
   parameter int         ADDR_W      = 10,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] RST_VAL     = 8'h01,
   parameter bit         IRQ_ACT_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              dma_cycle,
   input  logic              stat_a_in,
   input  logic              stat_b_in,
   input  logic              irq_req,
   output logic              access_sel,
   output logic [2:0]        reg_idx,
   output logic              int1_out,
   output logic              int1_oe,
   output logic              int2_out,
   output logic              int2_oe,
   output logic              cs_n_out,
   output logic              cs_oe
);

   ctrl_t ctrl;
   logic  hit;

   serwin_ctrl_reg #(
      .RST_VAL     (RST_VAL),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .stat_in ({stat_b_in, stat_a_in}),
      .rd_data (rd_data),
      .ctrl    (ctrl)
   );

   serwin_addr_match #(
      .ADDR_W (ADDR_W)
   ) u_match (
      .host_addr (host_addr),
      .dma_cycle (dma_cycle),
      .dec_en    (ctrl.dec_en),
      .win       (ctrl.win),
      .hit       (hit),
      .idx       (reg_idx)
   );

   serwin_irq_steer #(
      .IRQ_ACT_LOW (IRQ_ACT_LOW)
   ) u_irq (
      .irq_req  (irq_req),
      .dual_irq (ctrl.dual_irq),
      .win      (ctrl.win),
      .int1_out (int1_out),
      .int1_oe  (int1_oe),
      .int2_out (int2_out),
      .int2_oe  (int2_oe)
   );

   serwin_pin_ctl u_pin (
      .pin_mux   (ctrl.pin_mux),
      .dec_en    (ctrl.dec_en),
      .cs_export (ctrl.cs_export),
      .hit       (hit),
      .cs_n_out  (cs_n_out),
      .cs_oe     (cs_oe)
   );

   assign access_sel = hit;

endmodule

// File: rtl/serwin_decode_chk.sv
module serwin_decode_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic [7:0] rd_data,
   input logic       dma_cycle,
   input logic       access_sel,
   input logic [2:0] reg_idx,
   input logic       int1_oe,
   input logic       int2_oe,
   input logic       cs_n_out,
   input logic       cs_oe
);

   AST_DMA_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      dma_cycle |-> !access_sel); // R3

   AST_IDX_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !access_sel |-> (reg_idx == 3'd0)); // R4

   AST_DECODER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[5] |-> !access_sel); // R5

   AST_ONE_IRQ_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({int1_oe, int2_oe}) == 1); // R6

   AST_SINGLE_LINE1: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[6] |-> (int1_oe && !int2_oe)); // R7

   AST_CS_INPUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_oe |-> cs_n_out); // R9

   AST_CS_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      cs_oe |-> (cs_n_out == !access_sel)); // R9

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((rd_data & 8'hF9) == ($past(wr_data) & 8'hF9))); // R10

endmodule

bind serwin_decode serwin_decode_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .rd_data    (rd_data),
   .dma_cycle  (dma_cycle),
   .access_sel (access_sel),
   .reg_idx    (reg_idx),
   .int1_oe    (int1_oe),
   .int2_oe    (int2_oe),
   .cs_n_out   (cs_n_out),
   .cs_oe      (cs_oe)
);

// File: tb/serwin_decode_tb_top.sv
module serwin_decode_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic [9:0] host_addr = 10'h000;
   logic       dma_cycle = 1'b0;
   logic       stat_a_in = 1'b0;
   logic       stat_b_in = 1'b0;
   logic       irq_req = 1'b0;
   logic       access_sel;
   logic [2:0] reg_idx;
   logic       int1_out, int1_oe, int2_out, int2_oe;
   logic       cs_n_out, cs_oe;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;
   logic [7:0]  ctrl_m = 8'h01;   // bench model of writable bits
   bit          done = 1'b0;

   always #2 clk = ~clk;

   serwin_decode dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .host_addr(host_addr), .dma_cycle(dma_cycle),
      .stat_a_in(stat_a_in), .stat_b_in(stat_b_in), .irq_req(irq_req),
      .access_sel(access_sel), .reg_idx(reg_idx),
      .int1_out(int1_out), .int1_oe(int1_oe),
      .int2_out(int2_out), .int2_oe(int2_oe),
      .cs_n_out(cs_n_out), .cs_oe(cs_oe)
   );

   function automatic logic [9:0] exp_base(input logic [1:0] w);
      case (w)
         2'd0:    return 10'h3F8;
         2'd1:    return 10'h2F8;
         2'd2:    return 10'h3E8;
         default: return 10'h2E8;
      endcase
   endfunction

   function automatic logic exp_sel(input logic [7:0] c, input logic [9:0] a,
                                    input logic d);
      logic [9:0] b;
      b = exp_base(c[4:3]);
      return c[5] && !d && (a >= b) && (a <= b + 10'd7);
   endfunction

   task automatic chk(input string req, input logic [7:0] act,
                      input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%02h expected 0x%02h (ctrl=0x%02h addr=0x%03h dma=%0b)",
                  req, act, exp, ctrl_m, host_addr, dma_cycle);
      end
   endtask

   task automatic wr_ctrl(input logic [7:0] v);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = v;
      @(negedge clk);
      wr_en   = 1'b0;
      ctrl_m  = v & 8'hF9;
   endtask

   // Apply one bus state at a negedge, then compare every output.
   task automatic apply(input logic [9:0] a, input logic d, input logic irq);
      logic       s;
      logic       l2;
      logic       oe_cs;
      @(negedge clk);
      host_addr = a;
      dma_cycle = d;
      irq_req   = irq;
      #1;
      s     = exp_sel(ctrl_m, a, d);
      l2    = ctrl_m[6] && ctrl_m[3];
      oe_cs = ctrl_m[0] && ctrl_m[5] && ctrl_m[7];
      chk("R3 access_sel", {7'd0, access_sel}, {7'd0, s});
      chk("R4 reg_idx", {5'd0, reg_idx}, s ? {5'd0, a[2:0]} : 8'd0);
      if (ctrl_m[6]) begin
         chk("R6 line enables", {6'd0, int2_oe, int1_oe}, {6'd0, l2, !l2});
         chk("R6 line levels", {6'd0, int2_out, int1_out},
             {6'd0, l2 && irq, !l2 && irq});
      end else begin
         chk("R7 line enables", {6'd0, int2_oe, int1_oe}, 8'b01);
         chk("R7 line levels", {6'd0, int2_out, int1_out}, {7'd0, irq});
      end
      chk("R9 cs pin", {6'd0, cs_oe, cs_n_out},
          {6'd0, oe_cs, !(oe_cs && s)});
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1077));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 reset state
      #1;
      chk("R1 reset readback", rd_data, 8'h01);
      chk("R1 reset outputs", {4'd0, access_sel, int1_oe, int2_oe, cs_oe}, 8'b0100);

      // R5 decoder disabled: window 0 addresses never match
      apply(10'h3F8, 1'b0, 1'b1);
      apply(10'h3FF, 1'b0, 1'b0);

      // R2 sweep windows with edges, R3 DMA blocking, R4 index
      for (int w = 0; w < 4; w++) begin
         logic [9:0] b;
         b = exp_base(w[1:0]);
         wr_ctrl(8'h21 | (8'(w) << 3));
         chk("R10 readback", rd_data & 8'hF9, ctrl_m);
         apply(b - 10'd1, 1'b0, 1'b0);   // R2 just below
         apply(b,         1'b0, 1'b1);   // R2 first byte
         apply(b + 10'd5, 1'b0, 1'b0);
         apply(b + 10'd7, 1'b0, 1'b1);   // R2 last byte
         apply(b + 10'd8, 1'b0, 1'b0);   // R2 just above
         apply(b + 10'd3, 1'b1, 1'b1);   // R3 DMA cycle blocks
      end

      // R6 dual steering on every window
      for (int w = 0; w < 4; w++) begin
         wr_ctrl(8'h61 | (8'(w) << 3));
         apply(exp_base(w[1:0]) + 10'd1, 1'b0, 1'b1);
         apply(exp_base(w[1:0]) + 10'd1, 1'b0, 1'b0);
      end

      // R9 pin direction: export on, then bit 0 cleared, then DMA
      wr_ctrl(8'hA1 | (8'd2 << 3));
      apply(10'h3EA, 1'b0, 1'b0);
      apply(10'h3EA, 1'b1, 1'b0);
      apply(10'h3F0, 1'b0, 1'b0);
      wr_ctrl(8'hA0 | (8'd2 << 3));
      apply(10'h3EA, 1'b0, 1'b0);

      // R8 read-only status bits: written 1s dropped, pins shown after sync
      wr_ctrl(8'h07);
      stat_a_in = 1'b0; stat_b_in = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R8 written bits dropped", rd_data, 8'h01);
      @(negedge clk);
      stat_a_in = 1'b1; stat_b_in = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R8 pin A shown", rd_data, 8'h03);
      @(negedge clk);
      stat_a_in = 1'b0; stat_b_in = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk("R8 pin B shown", rd_data, 8'h05);
      @(negedge clk);
      stat_b_in = 1'b0;
      repeat (3) @(negedge clk);

      // Random mix: random control bytes, addresses near windows
      for (int i = 0; i < 1500; i++) begin
         logic [9:0] a;
         if ((i % 8) == 0) begin
            wr_ctrl(8'($urandom));
            chk("R10 random readback", rd_data, ctrl_m);
         end
         case ($urandom_range(0, 3))
            0:       a = 10'($urandom);
            default: a = exp_base(2'($urandom)) - 10'd4 + 10'($urandom_range(0, 15));
         endcase
         apply(a, ($urandom_range(0, 3) == 0), 1'($urandom));
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule